// File: doc/BRIEF.md
# Byte-Addressed 24-Pin GPIO Port Core

This core is a 24-pin general-purpose I/O port reached through a simple byte-wide register bus. The bus has separate write-enable, read-enable, address and data signals. Each pin has a direction bit and a pull-select bit. Output levels are held in a latch that software changes only through two write-only registers: one sets bits and one clears them. The synchronised levels on the input pins can be read back through a state register.

Every 24-bit quantity takes three consecutive byte addresses in little-endian order. A constant identification byte lets software confirm that the block is present. A one-bit enable in the system control register gates the whole port. While the enable is clear, every pin is an input and set or clear writes do nothing. A serial-bus slave or a host interconnect sits in front of the register bus. The pad drivers sit behind the pin outputs.

Top module: `gpio_port_core`

## Requirements
- R1: After a synchronous reset, the direction, pull-select, output latch and enable bit are all zero, so `pin_out`, `pin_oe`, `pin_pull_up` and `rdata` read 0.
- R2: A read of address 0x00 returns 0x7B. Writes to 0x00 change nothing.
- R3: A 24-bit register with base address B keeps bits 7:0 at B, bits 15:8 at B+1 and bits 23:16 at B+2. The direction register is at 0x60 and the pull-select register is at 0x68. Both read back the last byte written to each address.
- R4: A direction bit of 1 makes its pin an output, shown as `pin_oe` = 1, provided the enable bit is set. A pull-select bit of 1 gives `pin_pull_up` = 1 (pull-up), and 0 selects pull-down. `pin_oe` follows the direction and enable bits one clock after they change.
- R5: While the port is enabled, each 1 bit written to the set register at 0x6C–0x6E drives the matching `pin_out` bit high. Each 0 bit leaves its pin unchanged.
- R6: While the port is enabled, each 1 bit written to the clear register at 0x70–0x72 drives the matching `pin_out` bit low. Each 0 bit leaves its pin unchanged.
- R7: Bit 0 of the system control register at 0x40 enables the port. A read of 0x40 returns that bit in bit 0 and zeros in bits 7:1. While the bit is 0, `pin_oe` is all zero and set or clear writes leave the output latch unchanged.
- R8: The state register at 0x10–0x12 returns `pin_in` through a two-flop synchroniser. A read accepted in the first or second clock edge after an input changes returns the old level. A read accepted on the third edge returns the new level.
- R9: Reads of the set and clear addresses, and of every unmapped address, return 0x00. Writes to unmapped addresses and to the state register change nothing.
- R10: `rdata` is registered. It carries the addressed byte in the cycle after a read is accepted and holds its value while `rd_en` is low. A read and a write to the same address in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe for one byte |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_pull_up | output | NUM_PINS | 1 selects pull-up, 0 selects pull-down |

## Verification
Two events can fall in the same cycle: a read and a write to the same register byte, and a pin edge racing a read of the state register. The bench drives `rd_en` and `wr_en` together on a direction byte and expects the old byte, then reads the byte again and expects the new one. It also changes `pin_in` in the cycle a state read is issued. That read, and a read one cycle later, must both return the old level, and a read issued a cycle after that must return the new level. Random bursts of mixed reads and writes, with the enable bit toggling, are compared against a bench model of every register.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam logic [7:0] ADDR_ID    = 8'h00;
  localparam logic [7:0] ADDR_STATE = 8'h10;
  localparam logic [7:0] ADDR_CTRL  = 8'h40;
  localparam logic [7:0] ADDR_DIR   = 8'h60;
  localparam logic [7:0] ADDR_PULL  = 8'h68;
  localparam logic [7:0] ADDR_SET   = 8'h6C;
  localparam logic [7:0] ADDR_CLR   = 8'h70;
  localparam logic [7:0] ID_VALUE   = 8'h7B;

  typedef enum logic [2:0] {
    RG_NONE, RG_ID, RG_STATE, RG_CTRL, RG_DIR, RG_PULL, RG_SET, RG_CLR
  } reg_sel_e;
endpackage

// File: rtl/gpx_addr_decode.sv
module gpx_addr_decode
  import gpx_pkg::*;
#(
  parameter int LANES = 3,
  parameter int LW    = 2
) (
  input  logic [7:0]    addr,
  output reg_sel_e      sel,
  output logic [LW-1:0] lane
);
  function automatic logic in_win(input logic [7:0] a, input logic [7:0] b);
    int d;
    d = int'(a) - int'(b);
    return (d >= 0) && (d < LANES);
  endfunction

  always_comb begin
    sel  = RG_NONE;
    lane = '0;
    if (addr == ADDR_ID) begin
      sel = RG_ID;
    end else if (addr == ADDR_CTRL) begin
      sel = RG_CTRL;
    end else if (in_win(addr, ADDR_STATE)) begin
      sel  = RG_STATE;
      lane = LW'(addr - ADDR_STATE);
    end else if (in_win(addr, ADDR_DIR)) begin
      sel  = RG_DIR;
      lane = LW'(addr - ADDR_DIR);
    end else if (in_win(addr, ADDR_PULL)) begin
      sel  = RG_PULL;
      lane = LW'(addr - ADDR_PULL);
    end else if (in_win(addr, ADDR_SET)) begin
      sel  = RG_SET;
      lane = LW'(addr - ADDR_SET);
    end else if (in_win(addr, ADDR_CLR)) begin
      sel  = RG_CLR;
      lane = LW'(addr - ADDR_CLR);
    end
  end
endmodule

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
  import gpx_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int LANES    = NUM_PINS / 8,
  parameter int LW       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [LW-1:0]       lane,
  input  logic [7:0]          wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] pull_q,
  output logic [NUM_PINS-1:0] latch_q,
  output logic                en_q
);
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (wr_en && sel == RG_CTRL) en_q <= wdata[0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] dir_b, pull_b, lat_b;
    logic       hit;
    assign hit = wr_en && (lane == LW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_b  <= '0;
        pull_b <= '0;
        lat_b  <= '0;
      end else if (hit) begin
        case (sel)
          RG_DIR:  dir_b  <= wdata;
          RG_PULL: pull_b <= wdata;
          RG_SET:  if (en_q) lat_b <= lat_b | wdata;
          RG_CLR:  if (en_q) lat_b <= lat_b & ~wdata;
          default: ;
        endcase
      end
    end

    assign dir_q[g*8 +: 8]   = dir_b;
    assign pull_q[g*8 +: 8]  = pull_b;
    assign latch_q[g*8 +: 8] = lat_b;
  end
endmodule

// File: rtl/gpx_read_mux.sv
module gpx_read_mux
  import gpx_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int LANES    = NUM_PINS / 8,
  parameter int LW       = 2
) (
  input  reg_sel_e            sel,
  input  logic [LW-1:0]       lane,
  input  logic [NUM_PINS-1:0] state,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] pull,
  input  logic                en,
  output logic [7:0]          rbyte
);
  logic [7:0] st_b   [LANES];
  logic [7:0] dir_b  [LANES];
  logic [7:0] pull_b [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign st_b[g]   = state[g*8 +: 8];
    assign dir_b[g]  = dir[g*8 +: 8];
    assign pull_b[g] = pull[g*8 +: 8];
  end

  always_comb begin
    rbyte = 8'h00;
    case (sel)
      RG_ID:    rbyte = ID_VALUE;
      RG_CTRL:  rbyte = {7'b0, en};
      RG_STATE: rbyte = st_b[lane];
      RG_DIR:   rbyte = dir_b[lane];
      RG_PULL:  rbyte = pull_b[lane];
      default:  rbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
  import gpx_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pull_up
);
  localparam int LANES = NUM_PINS / 8;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  reg_sel_e            sel;
  logic [LW-1:0]       lane;
  logic [NUM_PINS-1:0] dir_q, pull_q, latch_q, state_q;
  logic                en_q;
  logic [7:0]          rbyte;

  gpx_addr_decode #(.LANES(LANES), .LW(LW)) dec_i (
    .addr(addr), .sel(sel), .lane(lane)
  );

  gpx_port_regs #(.NUM_PINS(NUM_PINS), .LANES(LANES), .LW(LW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .lane(lane),
    .wdata(wdata), .dir_q(dir_q), .pull_q(pull_q), .latch_q(latch_q),
    .en_q(en_q)
  );

  gpx_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(state_q)
  );

  gpx_read_mux #(.NUM_PINS(NUM_PINS), .LANES(LANES), .LW(LW)) mux_i (
    .sel(sel), .lane(lane), .state(state_q), .dir(dir_q), .pull(pull_q),
    .en(en_q), .rbyte(rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= 8'h00;
      pin_oe <= '0;
    end else begin
      if (rd_en) rdata <= rbyte;
      pin_oe <= en_q ? dir_q : '0;
    end
  end

  assign pin_out     = latch_q;
  assign pin_pull_up = pull_q;
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [7:0]          addr,
  input logic [7:0]          wdata,
  input logic [7:0]          rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                sys_en
);
  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 8'h00) |=> (rdata == 8'h7B));

  // R5
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sys_en && addr == 8'h6C) |=>
      (((pin_out[7:0] & $past(wdata)) == $past(wdata)) &&
       ((pin_out[7:0] & ~$past(wdata)) == ($past(pin_out[7:0]) & ~$past(wdata)))));

  // R6
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sys_en && addr == 8'h70) |=>
      (((pin_out[7:0] & $past(wdata)) == 8'h00) &&
       ((pin_out[7:0] & ~$past(wdata)) == ($past(pin_out[7:0]) & ~$past(wdata)))));

  // R7
  off_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_en |=> (pin_oe == '0));

  // R7
  off_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sys_en && (addr == 8'h6D || addr == 8'h71)) |=> $stable(pin_out));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == 8'h80 || addr == 8'h6C || addr == 8'h72)) |=> (rdata == 8'h00));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_port_core gpx_port_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .sys_en(en_q)
);

// File: tb/gpio_port_core_tb.sv
module gpio_port_core_tb_top;
  localparam int N = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0, wdata = '0;
  logic [7:0]   rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pin_pull_up;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [N-1:0] m_dir = '0, m_pull = '0, m_lat = '0;
  logic         m_en = 1'b0;

  always #5 clk = ~clk;

  gpio_port_core #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pull_up(pin_pull_up)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int o;
    if (a == 8'h00) return 8'h7B;
    if (a == 8'h40) return {7'b0, m_en};
    o = int'(a) - 'h60; if (o >= 0 && o < 3) return m_dir[o*8 +: 8];
    o = int'(a) - 'h68; if (o >= 0 && o < 3) return m_pull[o*8 +: 8];
    return 8'h00;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int o;
    if (a == 8'h40) m_en = d[0];
    o = int'(a) - 'h60; if (o >= 0 && o < 3) m_dir[o*8 +: 8] = d;
    o = int'(a) - 'h68; if (o >= 0 && o < 3) m_pull[o*8 +: 8] = d;
    o = int'(a) - 'h6C; if (o >= 0 && o < 3 && m_en) m_lat[o*8 +: 8] = m_lat[o*8 +: 8] | d;
    o = int'(a) - 'h70; if (o >= 0 && o < 3 && m_en) m_lat[o*8 +: 8] = m_lat[o*8 +: 8] & ~d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, model_read(a));
  endtask

  task automatic pins_chk(input string tag);
    @(negedge clk);
    chk({tag, " pin_out"}, pin_out, m_lat);
    chk({tag, " pin_oe"}, pin_oe, m_en ? m_dir : '0);
    chk({tag, " pin_pull_up"}, pin_pull_up, m_pull);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] addrs [20];
    void'($urandom(32'd2024));
    addrs = '{8'h00, 8'h10, 8'h11, 8'h12, 8'h40, 8'h60, 8'h61, 8'h62, 8'h68, 8'h69,
              8'h6A, 8'h6C, 8'h6D, 8'h6E, 8'h70, 8'h71, 8'h72, 8'h63, 8'h41, 8'h80};
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    @(negedge clk);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_pull_up", pin_pull_up, '0);
    chk("R1 rdata", rdata, '0);
    rd_chk("R1 dir", 8'h61);

    // R2 identification, write ignored
    wr(8'h00, 8'h55);
    rd(8'h00, d); chk("R2 id", d, 8'h7B);

    // R3 byte layout, R4 direction/pull
    wr(8'h40, 8'h01);
    wr(8'h60, 8'hA5); wr(8'h61, 8'h0F); wr(8'h62, 8'hC3);
    wr(8'h69, 8'h3C);
    rd(8'h62, d); chk("R3 dir hi", d, 8'hC3);
    rd(8'h61, d); chk("R3 dir mid", d, 8'h0F);
    rd(8'h69, d); chk("R3 pull mid", d, 8'h3C);
    pins_chk("R4");
    chk("R4 oe value", pin_oe, 24'hC30FA5);

    // R5 set, R6 clear
    wr(8'h6C, 8'h81); wr(8'h6E, 8'hF0);
    pins_chk("R5");
    chk("R5 out", pin_out, 24'hF00081);
    wr(8'h70, 8'h01); wr(8'h6E, 8'h00);
    pins_chk("R6");
    chk("R6 out", pin_out, 24'hF00080);

    // R7 disabled: no drive, set/clear ignored
    wr(8'h40, 8'hFE);
    rd(8'h40, d); chk("R7 ctrl", d, 8'h00);
    wr(8'h6D, 8'hFF); wr(8'h70, 8'hFF);
    pins_chk("R7 off");
    chk("R7 oe zero", pin_oe, '0);
    wr(8'h40, 8'h01);
    pins_chk("R7 on");
    chk("R7 out kept", pin_out, 24'hF00080);

    // R9 zero reads, ignored writes
    rd(8'h6C, d); chk("R9 set read", d, 8'h00);
    rd(8'h71, d); chk("R9 clr read", d, 8'h00);
    rd(8'h80, d); chk("R9 unmapped read", d, 8'h00);
    wr(8'h63, 8'hFF); wr(8'h10, 8'hFF); wr(8'h6B, 8'hFF);
    rd(8'h60, d); chk("R9 dir intact", d, 8'hA5);
    rd(8'h6A, d); chk("R9 pull intact", d, 8'h00);

    // R8 synchroniser latency: change pin with a read in flight
    @(negedge clk); pin_in = 24'h00005A; rd_en = 1; addr = 8'h10;
    @(negedge clk); chk("R8 edge1 old", rdata, 8'h00);
    @(negedge clk); chk("R8 edge2 old", rdata, 8'h00);
    @(negedge clk); rd_en = 0; chk("R8 edge3 new", rdata, 8'h5A);

    // R10 read and write same cycle
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 8'h61; wdata = 8'h77;
    @(negedge clk); rd_en = 0; wr_en = 0; model_write(8'h61, 8'h77);
    chk("R10 rd-wr old", rdata, 8'h0F);
    repeat (3) @(negedge clk);
    chk("R10 hold", rdata, 8'h0F);
    rd_chk("R10 new", 8'h61);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a;
      a = addrs[$urandom % 20];
      if (it % 40 == 0) begin
        pin_in = N'($urandom);
        repeat (3) @(negedge clk);
        rd(8'h10, d); chk("R8 rand lo", d, pin_in[7:0]);
        rd(8'h12, d); chk("R8 rand hi", d, pin_in[23:16]);
      end
      if ($urandom % 2) wr(a, 8'($urandom));
      else if (a >= 8'h10 && a <= 8'h12) begin
        rd(a, d); chk("R8 rand state", d, pin_in[(int'(a) - 'h10)*8 +: 8]);
      end else rd_chk("R3 rand read", a);
      if (it % 16 == 0) pins_chk("R4 rand pins");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule